// File: doc/BRIEF.md
# Programmable IIR Notch Filter

This block removes a narrow band of frequencies from a stream of signed audio samples with a second-order recursive filter. Two 14-bit coefficients fix the filter: one sets the width of the rejected band, the other sets where that band is centred. Host software works out the coefficient values from the wanted frequencies. It loads them as seven-bit halves through a small register write port.

Written halves are first held in a staging set. The filter goes on using its active set until a write carries the update flag. At that point the whole staged set becomes active in one step, so the filter never runs with half of a new coefficient pair. A single enable bit selects between the filtered output and a straight pass-through. Each change of that bit clears the filter history, so old state causes no transient. Samples arrive with a per-sample valid strobe. Each result appears one clock later.

Top module: `notch_filter`

## Requirements
- R1: After reset, out_valid and out_sample are 0, both coefficients are 0 and the filter is disabled, so the first sample after reset passes through unchanged.
- R2: out_valid equals in_valid delayed by one clock. While the filter is disabled, each valid sample appears unchanged on out_sample one clock later.
- R3: While enabled, with stored coefficients A0 and A1, a0 = -A0/8192, a1 = -A1/4096 and b = (1+a0)/2, the output is y[n] = b·(x[n]+x[n-2]) + a1·(x[n-1]-y[n-1]) - a0·y[n-2]. It is rounded half-up to an integer and appears one clock after its sample. x and y hold the samples and results of earlier valid cycles.
- R4: A register write with bit 8 clear changes only the staging set. The filter keeps using its previous active coefficients.
- R5: A write with bit 8 set, to any of the four coefficient addresses, first stores its own seven-bit field. On the same clock edge it then copies the complete staged set to the active set.
- R6: Register map, relative to BASE_ADDR (default 27): offset 0 holds A0[13:7], offset 1 holds A0[6:0], offset 2 holds A1[13:7] and offset 3 holds A1[6:0], each in data bits [6:0]. A0 and A1 are 14-bit two's complement numbers.
- R7: Bit 7 of every write to offset 0 becomes the filter enable (1 = filter, 0 = pass-through). It takes effect for the next sample and does not wait for the update flag.
- R8: A filtered result beyond the signed DATA_W-bit range is clamped to the largest or smallest representable value.
- R9: When the enable value changes, all stored samples and results are cleared. The first sample afterwards is filtered against zero history.
- R10: Writes to addresses outside the four coefficient registers change neither the coefficients nor the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (7) | Register write address |
| reg_wdata | input | 9 | Register write data (bit 8 update flag, bit 7 enable at offset 0) |
| in_valid | input | 1 | Input sample valid |
| in_sample | input | DATA_W (24) | Signed input sample |
| out_valid | output | 1 | Output sample valid |
| out_sample | output | DATA_W (24) | Signed filtered or bypassed sample |

## Verification
The assertions assume that every input is a known value in each cycle after reset, and that the four coefficient addresses fit inside the address space without wrapping. The accumulator is sized for the full coefficient and sample ranges, so no coefficient value can break the bypass, latency or register checks. The stimulus changes inputs only on the falling clock edge and never leaves a bit undefined. It leaves an idle cycle between an enable change and the next sample, so the history-clearing rule is exercised at a known point.

// File: rtl/notch_pkg.sv
// Shared constants and types for the notch filter: coefficient width,
// register field layout and the packed coefficient pair.
// Assumes a 14-bit coefficient split into two equal halves.
package notch_pkg;
    localparam int COEF_W     = 14;
    localparam int HALF_W     = COEF_W / 2;
    localparam int NUM_FIELDS = 4;
    localparam int REG_W      = 9;
    localparam int FLAG_BIT   = 8;
    localparam int EN_BIT     = 7;

    // Field order within the register window (decoded by offset)
    localparam int FLD_A0_HI = 0;
    localparam int FLD_A0_LO = 1;
    localparam int FLD_A1_HI = 2;
    localparam int FLD_A1_LO = 3;

    typedef struct packed {
        logic signed [COEF_W-1:0] a0;
        logic signed [COEF_W-1:0] a1;
    } coef_t;
endpackage

// File: rtl/notch_regs.sv
// Register window of the notch filter. It holds four staged coefficient
// halves, the active coefficient pair and the enable bit. A write with the
// flag bit set stores its own field and then commits all staged halves.
// Assumes BASE_ADDR + NUM_FIELDS - 1 fits in ADDR_W bits.
module notch_regs
    import notch_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int BASE_ADDR = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output coef_t             active,
    output logic              enable
);
    localparam int SEL_W = $clog2(NUM_FIELDS);

    logic [ADDR_W-1:0] offset;
    logic              hit;
    logic [SEL_W-1:0]  sel;
    logic [HALF_W-1:0] stage_q [NUM_FIELDS];
    logic [HALF_W-1:0] stage_d [NUM_FIELDS];

    // Decode whether this write lands in the coefficient window
    always_comb begin
        offset = addr - ADDR_W'(BASE_ADDR);
        hit    = wr && (offset < ADDR_W'(NUM_FIELDS));
        sel    = offset[SEL_W-1:0];
    end

    // Next staged halves: the addressed field takes the write data
    always_comb begin
        for (int i = 0; i < NUM_FIELDS; i++) begin
            stage_d[i] = (hit && sel == SEL_W'(i)) ? wdata[HALF_W-1:0] : stage_q[i];
        end
    end

    // Stage fields, commit on flag, track enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_FIELDS; i++) stage_q[i] <= '0;
            active <= '0;
            enable <= 1'b0;
        end else begin
            for (int i = 0; i < NUM_FIELDS; i++) stage_q[i] <= stage_d[i];
            if (hit && wdata[FLAG_BIT]) begin
                active.a0 <= {stage_d[FLD_A0_HI], stage_d[FLD_A0_LO]};
                active.a1 <= {stage_d[FLD_A1_HI], stage_d[FLD_A1_LO]};
            end
            if (hit && sel == SEL_W'(FLD_A0_HI)) enable <= wdata[EN_BIT];
        end
    end
endmodule

// File: rtl/notch_core.sv
// Direct-form-I datapath of the two-coefficient notch filter. It computes
// y = b(x0+x2) + a1(x1-y1) - a0*y2 in fixed point with 2^COEF_W scaling,
// rounds half-up and saturates. In bypass the sample passes through. An
// enable change zeroes the history (taken as zero in the same cycle).
// Assumes coefficients arrive already committed; latency is one clock.
module notch_core
    import notch_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  coef_t                    coef,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_sample
);
    localparam int ACC_W = DATA_W + COEF_W + 8;
    localparam int FRAC  = COEF_W;
    localparam logic signed [ACC_W-1:0] UNITY  = ACC_W'(1) <<< (COEF_W - 1);
    localparam logic signed [ACC_W-1:0] RND    = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] SAT_HI = (ACC_W'(1) <<< (DATA_W - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);

    logic signed [DATA_W-1:0] x1_q, x2_q, y1_q, y2_q;
    logic signed [DATA_W-1:0] hx1, hx2, hy1, hy2;
    logic                     en_q, fresh;
    logic signed [ACC_W-1:0]  g0, g1, g2, s02, d1, acc, shifted;
    logic signed [DATA_W-1:0] y_filt;

    // History seen by this cycle: zero right after an enable change
    always_comb begin
        fresh = (en != en_q);
        hx1   = fresh ? '0 : x1_q;
        hx2   = fresh ? '0 : x2_q;
        hy1   = fresh ? '0 : y1_q;
        hy2   = fresh ? '0 : y2_q;
    end

    // Fixed-point difference equation with rounding and clamping
    always_comb begin
        g0      = UNITY - ACC_W'(coef.a0);
        g1      = -(ACC_W'(coef.a1) <<< 2);
        g2      = ACC_W'(coef.a0) <<< 1;
        s02     = ACC_W'(in_sample) + ACC_W'(hx2);
        d1      = ACC_W'(hx1) - ACC_W'(hy1);
        acc     = g0 * s02 + g1 * d1 + g2 * ACC_W'(hy2) + RND;
        shifted = acc >>> FRAC;
        if (shifted > SAT_HI)      y_filt = DATA_W'(SAT_HI);
        else if (shifted < SAT_LO) y_filt = DATA_W'(SAT_LO);
        else                       y_filt = DATA_W'(shifted);
    end

    // Output register: filtered or bypassed sample, valid delayed by one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_sample <= en ? y_filt : in_sample;
        end
    end

    // Delay line: shift on filtered samples, clear on enable change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            x1_q <= '0;
            x2_q <= '0;
            y1_q <= '0;
            y2_q <= '0;
        end else begin
            en_q <= en;
            if (in_valid && en) begin
                x1_q <= in_sample;
                x2_q <= hx1;
                y1_q <= y_filt;
                y2_q <= hy1;
            end else if (fresh) begin
                x1_q <= '0;
                x2_q <= '0;
                y1_q <= '0;
                y2_q <= '0;
            end
        end
    end
endmodule

// File: rtl/notch_filter.sv
// Top of the programmable notch filter: the register window feeding a
// double-buffered coefficient pair into the filter datapath.
// Assumes a single clock domain and synchronous active-low reset.
module notch_filter
    import notch_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int ADDR_W    = 7,
    parameter int BASE_ADDR = 27
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [REG_W-1:0]         reg_wdata,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_sample
);
    coef_t                    coef_act;
    logic                     filt_en;
    logic signed [COEF_W-1:0] coef_a0, coef_a1;

    // Expose active coefficients as plain signals
    always_comb begin
        coef_a0 = coef_act.a0;
        coef_a1 = coef_act.a1;
    end

    notch_regs #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .active (coef_act),
        .enable (filt_en)
    );

    notch_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (filt_en),
        .coef       (coef_act),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );
endmodule

// File: rtl/notch_filter_chk.sv
// Property checker for notch_filter, bound to every instance of it.
// Assumes inputs are known after reset and the register window does not wrap.
module notch_filter_chk
    import notch_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int ADDR_W    = 7,
    parameter int BASE_ADDR = 27
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_wr,
    input logic [ADDR_W-1:0]        reg_addr,
    input logic [REG_W-1:0]         reg_wdata,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] in_sample,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_sample,
    input logic                     enable,
    input logic signed [COEF_W-1:0] coef_a0,
    input logic signed [COEF_W-1:0] coef_a1
);
    logic in_window;

    // Whether the current address hits one of the coefficient registers
    always_comb begin
        in_window = (reg_addr >= ADDR_W'(BASE_ADDR)) &&
                    (reg_addr <= ADDR_W'(BASE_ADDR + NUM_FIELDS - 1));
    end

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_bypass_passes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !enable) |=> (out_sample == $past(in_sample)));

    assert_coef_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_wdata[FLAG_BIT] && in_window) |=> ($stable(coef_a0) && $stable(coef_a1)));

    assert_commit_own_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[FLAG_BIT] && reg_addr == ADDR_W'(BASE_ADDR + FLD_A1_LO))
        |=> (coef_a1[HALF_W-1:0] == $past(reg_wdata[HALF_W-1:0])));

    assert_enable_direct_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(BASE_ADDR)) |=> (enable == $past(reg_wdata[EN_BIT])));
endmodule

bind notch_filter notch_filter_chk #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .out_valid  (out_valid),
    .out_sample (out_sample),
    .enable     (filt_en),
    .coef_a0    (coef_a0),
    .coef_a1    (coef_a1)
);

// File: tb/notch_filter_test.sv
`timescale 1ns/1ps
module notch_filter_test;
    localparam int DW   = 24;
    localparam int AW   = 7;
    localparam int BASE = 27;
    localparam longint YMAX = (64'sd1 <<< (DW - 1)) - 1;
    localparam longint YMIN = -(64'sd1 <<< (DW - 1));

    localparam logic signed [DW-1:0] STIM [16] = '{
        24'sd1000000, -24'sd1000000, 24'sd4000000, 24'sd0,
        24'sd123456, -24'sd3000000, 24'sd8388607, 24'h800000,
        24'sd500, -24'sd77777, 24'sd2500000, 24'sd2500000,
        24'sd2500000, -24'sd1, 24'sd42, -24'sd6000000
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 reg_wr = 1'b0;
    logic [AW-1:0]        reg_addr = '0;
    logic [8:0]           reg_wdata = '0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_sample = '0;
    logic                 out_valid;
    logic signed [DW-1:0] out_sample;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    // Bench mirror of the register state and filter history
    logic [6:0] st [4];
    int     m_a0 = 0, m_a1 = 0;
    bit     m_en = 1'b0;
    longint hx1 = 0, hx2 = 0, hy1 = 0, hy2 = 0;

    always #10 clk = ~clk;

    notch_filter #(.DATA_W(DW), .ADDR_W(AW), .BASE_ADDR(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    task automatic check(input string req, input longint act, input longint exp, input longint tol);
        longint d;
        n_vec++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Real-valued reference of the difference equation (rounded, clamped)
    function automatic longint model_step(input longint x);
        real a0r, a1r, br, v;
        longint y;
        if (!m_en) return x;
        a0r = -real'(m_a0) / 8192.0;
        a1r = -real'(m_a1) / 4096.0;
        br  = (1.0 + a0r) / 2.0;
        v   = br * real'(x + hx2) + a1r * real'(hx1 - hy1) - a0r * real'(hy2);
        y   = longint'($floor(v + 0.5));
        if (y > YMAX) y = YMAX;
        if (y < YMIN) y = YMIN;
        hx2 = hx1; hx1 = x; hy2 = hy1; hy1 = y;
        return y;
    endfunction

    task automatic reg_write(input int addr, input logic [8:0] d);
        logic signed [13:0] t;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(addr); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (addr >= BASE && addr <= BASE + 3) begin
            st[addr - BASE] = d[6:0];
            if (addr == BASE && d[7] != m_en) begin
                m_en = d[7];
                hx1 = 0; hx2 = 0; hy1 = 0; hy2 = 0;
            end
            if (d[8]) begin
                t = {st[0], st[1]}; m_a0 = int'(t);
                t = {st[2], st[3]}; m_a1 = int'(t);
            end
        end
    endtask

    task automatic push(input logic signed [DW-1:0] x, input string req);
        longint exp;
        exp = model_step(longint'(x));
        @(negedge clk);
        in_valid = 1'b1; in_sample = x;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, longint'(out_valid), 1, 0);
        check(req, longint'(out_sample), exp, 2);
    endtask

    // Watchdog: a hung run is a failed check and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) st[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state of the outputs
        check("R1 out_valid at reset", longint'(out_valid), 0, 0);
        check("R1 out_sample at reset", longint'(out_sample), 0, 0);
        rst_n = 1'b1;
        push(24'sd12345, "R1 first sample passes through");

        // R2: bypass, valid delayed by one clock
        push(-24'sd54321, "R2 bypass negative");
        push(24'sd8388607, "R2 bypass max");
        @(negedge clk);
        check("R2 no valid without input", longint'(out_valid), 0, 0);

        // R6/R7/R4: stage a0=0.5 (A0=-4096) and a1=-0.8 (A1=3277), enable, no flag
        reg_write(BASE + 0, {1'b0, 1'b1, 7'h60});
        reg_write(BASE + 1, {1'b0, 1'b0, 7'h00});
        reg_write(BASE + 2, {1'b0, 1'b0, 7'd25});
        @(negedge clk);
        push(24'sd1000000, "R4 staged values unused (R7 enable active)");
        push(24'sd2000000, "R4 staged values unused");

        // R5/R6: commit through the last register with its own field
        reg_write(BASE + 3, {1'b1, 1'b0, 7'd77});
        // R3: table of stimulus walked through the filter
        for (int i = 0; i < 16; i++) push(STIM[i], "R3 filtered table");

        // R5: commit from offset 1 while changing A1 to -0.4 (A1=1638)
        reg_write(BASE + 2, {1'b0, 1'b0, 7'd12});
        reg_write(BASE + 3, {1'b0, 1'b0, 7'd102});
        push(24'sd700000, "R5 before flag keeps old set");
        reg_write(BASE + 1, {1'b1, 1'b0, 7'h00});
        push(24'sd700000, "R5 commit from another register");
        push(-24'sd300000, "R5 new set in use");

        // R10: out-of-window writes with flag and data are ignored
        reg_write(BASE - 1, 9'h1FF);
        reg_write(BASE + 4, 9'h1FF);
        reg_write(BASE + 4, 9'h07F);
        push(24'sd900000, "R10 outside writes ignored");
        push(-24'sd900000, "R10 outside writes ignored");

        // R8: A0=0, A1=-8192 (a1=2) drives the result beyond range
        reg_write(BASE + 0, {1'b0, 1'b1, 7'h00});
        reg_write(BASE + 1, {1'b0, 1'b0, 7'h00});
        reg_write(BASE + 2, {1'b0, 1'b0, 7'h40});
        reg_write(BASE + 3, {1'b1, 1'b0, 7'h00});
        push(24'sd8388607, "R8 saturation setup");
        push(24'sd8388607, "R8 clamp high");
        check("R8 clamp high value", longint'(out_sample), YMAX, 0);
        push(24'h800000, "R8 saturation step");
        push(24'h800000, "R8 clamp low");
        check("R8 clamp low value", longint'(out_sample), YMIN, 0);

        // R7: disable without flag gives pass-through at once
        reg_write(BASE + 0, {1'b0, 1'b0, 7'h00});
        @(negedge clk);
        push(24'sd333333, "R7 disable applies to next sample");
        // R9: re-enable clears history, result is round(x/2)
        reg_write(BASE + 0, {1'b0, 1'b1, 7'h00});
        @(negedge clk);
        push(24'sd1001, "R9 history cleared on enable change");
        check("R9 half of input", longint'(out_sample), 501, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule